// File: doc/BRIEF.md
# Dual-Path Variable-Length Instruction Decoder

This block sits between an instruction byte window and a two-wide in-order issue stage. Instructions are 1, 2 or 3 bytes long. The length is coded in the two least significant bits of the first byte, so the start of the next instruction is only known once the current one has been looked at. The decoder walks the window from a fetch pointer and hands decoded instructions downstream in program order, at most two per clock.

There are two routes. The careful route examines one start byte over three clocks and never guesses. Every instruction it finishes correctly leaves a start mark in a per-byte tag store. The quick route runs only where such a mark exists. It decodes the instruction at the pointer in one clock, and it adds a second instruction in the same clock when the byte right after the first instruction is also marked. Code runs slowly the first time through and at up to two per clock after that.

The window is filled through a byte write port. A redirect input points the decoder at a new address. A flush input forgets all learned marks. Output is a two-slot valid/ready stream. A transfer happens on a clock edge where `slot_vld[0]` and `dec_ready` are both high. While `dec_ready` is low, a presented pair stays exactly as it is and no further decoding is committed.

Top module: `dual_path_decoder`

## Requirements
- R1: Length code (bits 1:0 of the first byte): 01 gives 1 byte, 10 gives 2, 11 gives 3. Code 00 is illegal. It is presented alone in slot 0 with `s0_bad`=1 and `s0_len`=0, and the decoder then stays idle until a redirect.
- R2: At an unmarked start address the careful route presents the result in slot 0 alone, on the third clock edge after the edge that placed the pointer there. It never presents more than one instruction per three clocks.
- R3: A legal instruction finished by the careful route marks its start byte. An illegal one leaves no mark, and neither does an abandoned one.
- R4: At a marked start address with a legal length code, slot 0 is presented on the very next clock edge.
- R5: Slot 1 is filled only when the byte at slot-0 address plus slot-0 length is marked. Slot 0 always holds the older instruction, `s1_pc` = `s0_pc` + `s0_len` modulo the window size, and slot 1 is never valid without slot 0.
- R6: While a slot is valid and `dec_ready` is low, every output holds its value and the pointer does not advance.
- R7: A redirect loads the pointer on the next edge and drops any careful decode in progress. It keeps all marks and any pair already presented, and it takes priority over decoding in that cycle.
- R8: Reset clears all marks and all slots, and the decoder stays idle until the first redirect. A `flush_tags` pulse clears all marks.
- R9: A write through the fill port stores the byte, and later decodes show it as the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_we | input | 1 | Window byte write strobe |
| fill_addr | input | AW | Window byte address |
| fill_data | input | 8 | Byte to write |
| flush_tags | input | 1 | Clear all start marks |
| redir_valid | input | 1 | Load a new fetch pointer |
| redir_pc | input | AW | New fetch pointer |
| slot_vld | output | 2 | Slot valid bits (bit 0 = older slot) |
| dec_ready | input | 1 | Downstream accepts the presented pair |
| s0_pc | output | AW | Slot 0 start address |
| s0_len | output | 2 | Slot 0 length in bytes |
| s0_op | output | 8 | Slot 0 first byte |
| s0_bad | output | 1 | Slot 0 holds an illegal instruction |
| s1_pc | output | AW | Slot 1 start address |
| s1_len | output | 2 | Slot 1 length in bytes |
| s1_op | output | 8 | Slot 1 first byte |

## Verification
Each result has a fixed delay after the edge that places the pointer or takes a redirect. A marked start shows up one edge later and an unmarked one three edges later. Held outputs stay put for as long as ready stays low, and a released pair gives way to the next pair on the following edge. The vector table gives every expected beat as an edge count after its redirect. The bench drives inputs and samples outputs on falling edges, and it also checks that the slots are empty at every falling edge between two expected beats. That way a result that comes one cycle early, one cycle late, or from an abandoned decode is reported.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_RUN  = 2'd1,
    ST_SLOW = 2'd2
  } dstate_e;

  typedef struct packed {
    logic [7:0] op;
    logic [1:0] len;
    logic       bad;
  } ifld_t;

  function automatic logic [1:0] len_code(input logic [7:0] first);
    return first[1:0];
  endfunction

endpackage

// File: rtl/dpd_window.sv
module dpd_window #(
  parameter int WIN = 64,
  parameter int AW  = 6,
  parameter int NRD = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    tag_set,
  input  logic [AW-1:0]           tag_addr,
  input  logic                    tag_clr,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][7:0]     rd_byte,
  output logic [NRD-1:0]          rd_tag
);

  logic [7:0]     mem [WIN];
  logic [WIN-1:0] tags_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tags_q <= '0;
    else if (tag_clr) tags_q <= '0;
    else if (tag_set) tags_q[tag_addr] <= 1'b1;
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_byte[k] = mem[rd_addr[k]];
    assign rd_tag[k]  = tags_q[rd_addr[k]];
  end

endmodule

// File: rtl/dpd_ctrl.sv
module dpd_ctrl
  import dpd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                redir_valid,
  input  logic [AW-1:0]       redir_pc,
  input  logic                load_ok,
  output logic [1:0][AW-1:0]  rd_addr,
  input  logic [1:0][7:0]     rd_byte,
  input  logic [1:0]          rd_tag,
  output logic                tag_set,
  output logic [AW-1:0]       tag_addr,
  output logic                ld,
  output logic [1:0]          ld_vld,
  output logic [AW-1:0]       ld_pc0,
  output ifld_t               ld_f0,
  output logic [AW-1:0]       ld_pc1,
  output ifld_t               ld_f1
);

  localparam int PADW = AW - 2;

  dstate_e       st_q;
  logic [AW-1:0] pc_q;
  logic          step_q;
  logic [7:0]    sbyte_q;

  logic [1:0]    len0, len1, slen;
  logic [AW-1:0] nxt, after_pair;
  logic          fast0, fast1, slow_done;

  always_comb begin
    len0       = len_code(rd_byte[0]);
    nxt        = pc_q + {{PADW{1'b0}}, len0};
    rd_addr[0] = pc_q;
    rd_addr[1] = nxt;
    len1       = len_code(rd_byte[1]);
    after_pair = nxt + {{PADW{1'b0}}, len1};
    slen       = len_code(sbyte_q);

    fast0     = (st_q == ST_RUN) && rd_tag[0] && (len0 != 2'd0);
    fast1     = fast0 && rd_tag[1] && (len1 != 2'd0);
    slow_done = (st_q == ST_SLOW) && step_q && load_ok;

    ld     = !redir_valid && load_ok && (fast0 || slow_done);
    ld_vld = slow_done ? 2'b01 : {fast1, 1'b1};
    ld_pc0 = pc_q;
    ld_pc1 = nxt;
    if (slow_done) ld_f0 = '{op: sbyte_q, len: slen, bad: (slen == 2'd0)};
    else           ld_f0 = '{op: rd_byte[0], len: len0, bad: 1'b0};
    ld_f1 = '{op: rd_byte[1], len: len1, bad: 1'b0};

    tag_set  = slow_done && (slen != 2'd0) && !redir_valid;
    tag_addr = pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_HALT;
      pc_q    <= '0;
      step_q  <= 1'b0;
      sbyte_q <= '0;
    end else if (redir_valid) begin
      st_q   <= ST_RUN;
      pc_q   <= redir_pc;
      step_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (fast0) begin
            if (load_ok) pc_q <= fast1 ? after_pair : nxt;
          end else begin
            st_q    <= ST_SLOW;
            step_q  <= 1'b0;
            sbyte_q <= rd_byte[0];
          end
        end
        ST_SLOW: begin
          if (!step_q) begin
            step_q <= 1'b1;
          end else if (load_ok) begin
            step_q <= 1'b0;
            if (slen == 2'd0) begin
              st_q <= ST_HALT;
            end else begin
              st_q <= ST_RUN;
              pc_q <= pc_q + {{PADW{1'b0}}, slen};
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dpd_outreg.sv
module dpd_outreg
  import dpd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [1:0]    ld_vld,
  input  logic [AW-1:0] ld_pc0,
  input  ifld_t         ld_f0,
  input  logic [AW-1:0] ld_pc1,
  input  ifld_t         ld_f1,
  input  logic          ready,
  output logic          load_ok,
  output logic [1:0]    vld,
  output logic [AW-1:0] pc0,
  output ifld_t         f0,
  output logic [AW-1:0] pc1,
  output ifld_t         f1
);

  assign load_ok = !vld[0] || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      pc0 <= '0;
      pc1 <= '0;
      f0  <= '0;
      f1  <= '0;
    end else if (ld) begin
      vld <= ld_vld;
      pc0 <= ld_pc0;
      f0  <= ld_f0;
      pc1 <= ld_pc1;
      f1  <= ld_f1;
    end else if (ready) begin
      vld <= '0;
    end
  end

endmodule

// File: rtl/dual_path_decoder.sv
module dual_path_decoder
  import dpd_pkg::*;
#(
  parameter  int WIN_BYTES = 64,
  localparam int AW        = $clog2(WIN_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [7:0]    fill_data,
  input  logic          flush_tags,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_pc,
  output logic [1:0]    slot_vld,
  input  logic          dec_ready,
  output logic [AW-1:0] s0_pc,
  output logic [1:0]    s0_len,
  output logic [7:0]    s0_op,
  output logic          s0_bad,
  output logic [AW-1:0] s1_pc,
  output logic [1:0]    s1_len,
  output logic [7:0]    s1_op
);

  logic [1:0][AW-1:0] rd_addr;
  logic [1:0][7:0]    rd_byte;
  logic [1:0]         rd_tag;
  logic               tag_set, load_ok, ld;
  logic [AW-1:0]      tag_addr, ld_pc0, ld_pc1;
  logic [1:0]         ld_vld;
  ifld_t              ld_f0, ld_f1, f0, f1;

  dpd_window #(.WIN(WIN_BYTES), .AW(AW), .NRD(2)) u_win (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_we), .wr_addr(fill_addr), .wr_data(fill_data),
    .tag_set(tag_set), .tag_addr(tag_addr), .tag_clr(flush_tags),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_tag(rd_tag)
  );

  dpd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .load_ok(load_ok),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_tag(rd_tag),
    .tag_set(tag_set), .tag_addr(tag_addr),
    .ld(ld), .ld_vld(ld_vld),
    .ld_pc0(ld_pc0), .ld_f0(ld_f0), .ld_pc1(ld_pc1), .ld_f1(ld_f1)
  );

  dpd_outreg #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .ld(ld), .ld_vld(ld_vld),
    .ld_pc0(ld_pc0), .ld_f0(ld_f0), .ld_pc1(ld_pc1), .ld_f1(ld_f1),
    .ready(dec_ready), .load_ok(load_ok),
    .vld(slot_vld), .pc0(s0_pc), .f0(f0), .pc1(s1_pc), .f1(f1)
  );

  assign s0_op  = f0.op;
  assign s0_len = f0.len;
  assign s0_bad = f0.bad;
  assign s1_op  = f1.op;
  assign s1_len = f1.len;

endmodule

// File: rtl/dpd_checker.sv
module dpd_checker #(
  parameter int WIN_BYTES = 64,
  localparam int AW = $clog2(WIN_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_ready,
  input logic [1:0]    slot_vld,
  input logic [AW-1:0] s0_pc,
  input logic [1:0]    s0_len,
  input logic [7:0]    s0_op,
  input logic          s0_bad,
  input logic [AW-1:0] s1_pc,
  input logic [7:0]    s1_op
);

  assert_slot_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld[1] |-> slot_vld[0]);

  assert_pair_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld[1] |-> (s1_pc == s0_pc + {{(AW-2){1'b0}}, s0_len}));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld[0] && !dec_ready) |=> ($stable(slot_vld) && $stable(s0_pc) &&
      $stable(s0_op) && $stable(s0_bad) && $stable(s1_pc) && $stable(s1_op)));

  assert_bad_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld[0] && s0_bad) |-> (!slot_vld[1] && s0_len == 2'd0));

  assert_len_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld[0] && !s0_bad) |-> (s0_len != 2'd0 && s0_len == s0_op[1:0]));

endmodule

bind dual_path_decoder dpd_checker #(.WIN_BYTES(WIN_BYTES)) u_dpd_chk (
  .clk(clk), .rst_n(rst_n), .dec_ready(dec_ready), .slot_vld(slot_vld),
  .s0_pc(s0_pc), .s0_len(s0_len), .s0_op(s0_op), .s0_bad(s0_bad),
  .s1_pc(s1_pc), .s1_op(s1_op)
);

// File: tb/tb_dual_path_decoder.sv
`timescale 1ns/1ps
module tb_dual_path_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fill_we = 1'b0;
  logic [5:0] fill_addr = '0;
  logic [7:0] fill_data = '0;
  logic       flush_tags = 1'b0;
  logic       redir_valid = 1'b0;
  logic [5:0] redir_pc = '0;
  logic       dec_ready = 1'b1;
  logic [1:0] slot_vld;
  logic [5:0] s0_pc, s1_pc;
  logic [1:0] s0_len, s1_len;
  logic [7:0] s0_op, s1_op;
  logic       s0_bad;

  int total = 0;
  int bad = 0;
  int cur = 0;

  always #2 clk = ~clk;

  dual_path_decoder dut (
    .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .fill_addr(fill_addr),
    .fill_data(fill_data), .flush_tags(flush_tags), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .slot_vld(slot_vld), .dec_ready(dec_ready),
    .s0_pc(s0_pc), .s0_len(s0_len), .s0_op(s0_op), .s0_bad(s0_bad),
    .s1_pc(s1_pc), .s1_len(s1_len), .s1_op(s1_op)
  );

  typedef struct packed {
    logic       redir;
    logic [5:0] rpc;
    logic [7:0] at;
    logic [1:0] vld;
    logic [5:0] p0;
    logic [1:0] l0;
    logic [7:0] o0;
    logic       bd;
    logic [5:0] p1;
    logic [1:0] l1;
    logic [7:0] o1;
  } vec_t;

  // Program: 0:41 | 1:52 AA | 3:63 11 22 | 6:75 | 7:86 33 | 9:00 (illegal)
  localparam vec_t VECS [10] = '{
    '{1'b1, 6'd0, 8'd3,  2'b01, 6'd0, 2'd1, 8'h41, 1'b0, 6'd0, 2'd0, 8'h00},
    '{1'b0, 6'd0, 8'd6,  2'b01, 6'd1, 2'd2, 8'h52, 1'b0, 6'd0, 2'd0, 8'h00},
    '{1'b0, 6'd0, 8'd9,  2'b01, 6'd3, 2'd3, 8'h63, 1'b0, 6'd0, 2'd0, 8'h00},
    '{1'b0, 6'd0, 8'd12, 2'b01, 6'd6, 2'd1, 8'h75, 1'b0, 6'd0, 2'd0, 8'h00},
    '{1'b0, 6'd0, 8'd15, 2'b01, 6'd7, 2'd2, 8'h86, 1'b0, 6'd0, 2'd0, 8'h00},
    '{1'b0, 6'd0, 8'd18, 2'b01, 6'd9, 2'd0, 8'h00, 1'b1, 6'd0, 2'd0, 8'h00},
    '{1'b1, 6'd0, 8'd1,  2'b11, 6'd0, 2'd1, 8'h41, 1'b0, 6'd1, 2'd2, 8'h52},
    '{1'b0, 6'd0, 8'd2,  2'b11, 6'd3, 2'd3, 8'h63, 1'b0, 6'd6, 2'd1, 8'h75},
    '{1'b0, 6'd0, 8'd3,  2'b01, 6'd7, 2'd2, 8'h86, 1'b0, 6'd0, 2'd0, 8'h00},
    '{1'b0, 6'd0, 8'd6,  2'b01, 6'd9, 2'd0, 8'h00, 1'b1, 6'd0, 2'd0, 8'h00}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic beat(input string req, input logic [1:0] v, input logic [5:0] p0,
                      input logic [1:0] l0, input logic [7:0] o0, input logic bd,
                      input logic [5:0] p1, input logic [1:0] l1, input logic [7:0] o1);
    chk(req, "slot_vld", {30'd0, slot_vld}, {30'd0, v});
    chk(req, "s0_pc", {26'd0, s0_pc}, {26'd0, p0});
    chk(req, "s0_len", {30'd0, s0_len}, {30'd0, l0});
    chk(req, "s0_op", {24'd0, s0_op}, {24'd0, o0});
    chk(req, "s0_bad", {31'd0, s0_bad}, {31'd0, bd});
    if (v[1]) begin
      chk(req, "s1_pc", {26'd0, s1_pc}, {26'd0, p1});
      chk(req, "s1_len", {30'd0, s1_len}, {30'd0, l1});
      chk(req, "s1_op", {24'd0, s1_op}, {24'd0, o1});
    end
  endtask

  task automatic quiet(input string req);
    chk(req, "slot_vld idle", {30'd0, slot_vld}, 32'd0);
  endtask

  task automatic redirect(input logic [5:0] pc);
    redir_valid = 1'b1;
    redir_pc    = pc;
    tick();
    redir_valid = 1'b0;
  endtask

  task automatic put(input logic [5:0] a, input logic [7:0] d);
    fill_we = 1'b1; fill_addr = a; fill_data = d;
    tick();
    fill_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    quiet("R8 reset");
    put(6'd0, 8'h41); put(6'd1, 8'h52); put(6'd2, 8'hAA);
    put(6'd3, 8'h63); put(6'd4, 8'h11); put(6'd5, 8'h22);
    put(6'd6, 8'h75); put(6'd7, 8'h86); put(6'd8, 8'h33);
    put(6'd9, 8'h00);
    repeat (3) tick();
    quiet("R8 idle before redirect");

    // Vector table: pass 1 learns (R2, R3, R1), pass 2 runs on marks (R4, R5, R9)
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.redir) begin
        redirect(v.rpc);
        cur = 0;
        if (v.at > 0) quiet("R2 R4 gap");
      end
      while (cur < int'(v.at)) begin
        tick();
        cur++;
        if (cur < int'(v.at)) quiet("R2 R4 gap");
      end
      beat(v.redir ? "R4 R5 table" : "R2 R3 table", v.vld, v.p0, v.l0, v.o0, v.bd,
           v.p1, v.l1, v.o1);
    end

    // R1: halted after illegal
    for (int k = 0; k < 4; k++) begin
      tick();
      quiet("R1 halt after illegal");
    end

    // R6: back-pressure holds the pair and the pointer
    dec_ready = 1'b0;
    redirect(6'd0);
    tick();
    beat("R6 first", 2'b11, 6'd0, 2'd1, 8'h41, 1'b0, 6'd1, 2'd2, 8'h52);
    for (int k = 0; k < 3; k++) begin
      tick();
      beat("R6 held", 2'b11, 6'd0, 2'd1, 8'h41, 1'b0, 6'd1, 2'd2, 8'h52);
    end
    dec_ready = 1'b1;
    tick();
    beat("R6 resume", 2'b11, 6'd3, 2'd3, 8'h63, 1'b0, 6'd6, 2'd1, 8'h75);
    tick();
    beat("R6 resume", 2'b01, 6'd7, 2'd2, 8'h86, 1'b0, 6'd0, 2'd0, 8'h00);
    repeat (6) tick();

    // R8: flush forgets marks, so address 0 goes slow again
    flush_tags = 1'b1;
    tick();
    flush_tags = 1'b0;
    redirect(6'd0);
    quiet("R8 flush");
    tick(); quiet("R8 flush");
    tick(); quiet("R8 flush");
    tick();
    beat("R8 R2 slow after flush", 2'b01, 6'd0, 2'd1, 8'h41, 1'b0, 6'd0, 2'd0, 8'h00);
    tick();
    // R7: redirect while the decode of address 1 is in progress
    redirect(6'd6);
    quiet("R7 abandon");
    tick(); quiet("R7 abandon");
    tick(); quiet("R7 abandon");
    tick();
    beat("R7 new target", 2'b01, 6'd6, 2'd1, 8'h75, 1'b0, 6'd0, 2'd0, 8'h00);

    // R3 R7: mark at 0 survives redirects, abandoned 1 has no mark
    redirect(6'd0);
    tick();
    beat("R3 R5 single", 2'b01, 6'd0, 2'd1, 8'h41, 1'b0, 6'd0, 2'd0, 8'h00);
    tick(); quiet("R3 relearn");
    tick(); quiet("R3 relearn");
    tick();
    beat("R3 relearn", 2'b01, 6'd1, 2'd2, 8'h52, 1'b0, 6'd0, 2'd0, 8'h00);

    // R9: rewritten byte appears in the decode
    put(6'd6, 8'h79);
    redirect(6'd6);
    tick();
    beat("R9 R4 rewrite", 2'b01, 6'd6, 2'd1, 8'h79, 1'b0, 6'd0, 2'd0, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule